// File: doc/BRIEF.md
# Imaging Front-End Power-On Configuration Sequencer

This controller brings an imaging analog front-end from power-up to its operating state. Once the supply-good input has been sampled high, it waits a settling interval and then writes the control register with its reset bit forced low. After a two-millisecond gap it writes the same register again, this time with the reset bit forced high and every other bit unchanged. That write is held off while the vertical blanking input is active, so that the offset calibration it starts never runs inside the blanking window.

The calibration is allowed a fixed number of clock cycles. Only after that does the sequencer write the two remaining gain and clamp registers. It then raises a done flag and keeps it high.

Each register write goes to an external serial shifter as an address and data word, qualified by a request. The request is held until the shifter acknowledges it. The clock frequency sets the millisecond waits in cycles, and the register values and addresses are parameters. A step output shows the current phase. A drop of supply-good at any time returns the sequencer to idle.

Top module: `afe_bringup_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, step is 0, wr_req is low and done is low.
- R2: When pwr_good is first sampled high in idle, step becomes 1 for exactly T1 = ceil(CLK_HZ/1000) cycles. The first write request then appears.
- R3: The first write carries address CTRL_ADDR and data CTRL_VAL with bit RST_BIT forced to 0.
- R4: From the cycle after the first write is acknowledged, at least T2 = ceil(2*CLK_HZ/1000) cycles pass before the release write is requested. With vblank low the gap is exactly T2 cycles.
- R5: The release write carries address CTRL_ADDR and data CTRL_VAL with bit RST_BIT forced to 1. It differs from the first write's data in bit RST_BIT only.
- R6: From the cycle after the release write is acknowledged, exactly CAL_CYCLES cycles of calibration (step 5) pass before the next write is requested.
- R7: The release write request rises only after a clock edge at which vblank was sampled low. While vblank stays high past the end of the gap, the request is withheld.
- R8: wr_req, wr_addr and wr_data stay constant until wr_ack is sampled high. At the edge that samples wr_ack, the sequencer moves to the next step.
- R9: One bring-up issues exactly four writes, in this order: CTRL_ADDR with reset low, CTRL_ADDR with reset high, GAIN0_ADDR with GAIN0_VAL, and GAIN1_ADDR with GAIN1_VAL. The third write is requested the cycle after the release acknowledge's calibration ends. The fourth is requested the cycle after the third is acknowledged.
- R10: done rises at the edge that samples the acknowledge of the fourth write. It stays high while pwr_good stays high.
- R11: At the edge after pwr_good is sampled low, from any step, step becomes 0 and wr_req and done go low. Step stays 0 until pwr_good is high again, and the next bring-up starts from the beginning.
- R12: The step encoding is:
  - 0 idle
  - 1 settle
  - 2 reset-low write
  - 3 gap
  - 4 release write
  - 5 calibration
  - 6 first gain write
  - 7 second gain write
  - 8 ready

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_good | input | 1 | Supply and timing pulses are stable |
| vblank | input | 1 | Vertical blanking active |
| wr_ack | input | 1 | Serial shifter has accepted the pending write |
| wr_req | output | 1 | A register write is pending |
| wr_addr | output | ADDR_W | Register address of the pending write |
| wr_data | output | DATA_W | Register data of the pending write |
| done | output | 1 | Bring-up complete |
| step | output | 4 | Current sequencer step (encoding in R12) |

## Verification
The bench builds the block with CLK_HZ = 12345, which makes the millisecond waits 13 and 25 cycles. Neither division is exact, so the round-up is tested. It uses CAL_CYCLES = 150 and a control value whose reset bit is already set, so a failure to force that bit low in the first write is visible. These small values allow dozens of complete bring-ups in a short run. The runs use random acknowledge latencies, random blanking, supply drops at random points, and a directed blanking window that holds off the release write.

// File: rtl/afe_seq_pkg.sv
`timescale 1ns/1ps
package afe_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_SETTLE    = 4'd1,
        ST_CTRL_HOLD = 4'd2,
        ST_HOLD_GAP  = 4'd3,
        ST_CTRL_RUN  = 4'd4,
        ST_CALIB     = 4'd5,
        ST_GAIN0     = 4'd6,
        ST_GAIN1     = 4'd7,
        ST_READY     = 4'd8
    } seq_step_e;

    typedef struct packed {
        logic       req;
        logic [1:0] sel;
        logic       rst_level;
    } wr_cmd_t;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_GAIN0 = 2'd1;
    localparam logic [1:0] SEL_GAIN1 = 2'd2;

    function automatic int unsigned ms_to_cycles(int unsigned clk_hz, int unsigned ms);
        longint unsigned prod;
        prod = longint'(clk_hz) * longint'(ms);
        return int'((prod + 64'd999) / 64'd1000);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic wr_cmd_t step_cmd(seq_step_e s);
        wr_cmd_t c;
        c = '{req: 1'b0, sel: SEL_CTRL, rst_level: 1'b0};
        case (s)
            ST_CTRL_HOLD: c = '{req: 1'b1, sel: SEL_CTRL,  rst_level: 1'b0};
            ST_CTRL_RUN:  c = '{req: 1'b1, sel: SEL_CTRL,  rst_level: 1'b1};
            ST_GAIN0:     c = '{req: 1'b1, sel: SEL_GAIN0, rst_level: 1'b0};
            ST_GAIN1:     c = '{req: 1'b1, sel: SEL_GAIN1, rst_level: 1'b0};
            default:      c = '{req: 1'b0, sel: SEL_CTRL,  rst_level: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/afe_seq_timer.sv
`timescale 1ns/1ps
module afe_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt) == CNT_MAX && !$past(clr)) |-> (cnt == CNT_MAX));
endmodule

// File: rtl/afe_seq_fsm.sv
`timescale 1ns/1ps
module afe_seq_fsm
    import afe_seq_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned SETTLE_CYC = 10,
    parameter int unsigned GAP_CYC    = 20,
    parameter int unsigned CAL_CYC    = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_good,
    input  logic             vblank,
    input  logic             wr_ack,
    input  logic [CNT_W-1:0] cnt,
    output seq_step_e        state,
    output logic             clr
);
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LIM    = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LIM    = CNT_W'(CAL_CYC - 1);

    seq_step_e state_n;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:      if (pwr_good)                   state_n = ST_SETTLE;
            ST_SETTLE:    if (cnt >= SETTLE_LIM)          state_n = ST_CTRL_HOLD;
            ST_CTRL_HOLD: if (wr_ack)                     state_n = ST_HOLD_GAP;
            ST_HOLD_GAP:  if (cnt >= GAP_LIM && !vblank)  state_n = ST_CTRL_RUN;
            ST_CTRL_RUN:  if (wr_ack)                     state_n = ST_CALIB;
            ST_CALIB:     if (cnt >= CAL_LIM)             state_n = ST_GAIN0;
            ST_GAIN0:     if (wr_ack)                     state_n = ST_GAIN1;
            ST_GAIN1:     if (wr_ack)                     state_n = ST_READY;
            ST_READY:                                     state_n = ST_READY;
            default:                                      state_n = ST_IDLE;
        endcase
        if (!pwr_good) state_n = ST_IDLE;
    end

    assign clr = (state_n != state);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    assert_release_after_blank_low_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_CTRL_RUN) |-> !$past(vblank));

    assert_drop_to_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (state == ST_IDLE));

    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && pwr_good) |=> (state == ST_READY));
endmodule

// File: rtl/afe_seq_wrmux.sv
`timescale 1ns/1ps
module afe_seq_wrmux
    import afe_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RST_BIT = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 4'd2,
    parameter logic [ADDR_W-1:0] GAIN0_ADDR = 4'd0,
    parameter logic [ADDR_W-1:0] GAIN1_ADDR = 4'd1,
    parameter logic [DATA_W-1:0] CTRL_VAL   = 8'hA9,
    parameter logic [DATA_W-1:0] GAIN0_VAL  = 8'h3C,
    parameter logic [DATA_W-1:0] GAIN1_VAL  = 8'h81
) (
    input  seq_step_e         state,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;
    localparam logic [DATA_W-1:0] CTRL_LO  = CTRL_VAL & ~RST_MASK;
    localparam logic [DATA_W-1:0] CTRL_HI  = CTRL_VAL | RST_MASK;

    wr_cmd_t cmd;

    always_comb begin
        cmd     = step_cmd(state);
        wr_req  = cmd.req;
        wr_addr = '0;
        wr_data = '0;
        if (cmd.req) begin
            case (cmd.sel)
                SEL_GAIN0: begin wr_addr = GAIN0_ADDR; wr_data = GAIN0_VAL; end
                SEL_GAIN1: begin wr_addr = GAIN1_ADDR; wr_data = GAIN1_VAL; end
                default: begin
                    wr_addr = CTRL_ADDR;
                    wr_data = cmd.rst_level ? CTRL_HI : CTRL_LO;
                end
            endcase
        end
    end
endmodule

// File: rtl/afe_bringup_seq.sv
`timescale 1ns/1ps
module afe_bringup_seq
    import afe_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 36_000_000,
    parameter int unsigned CAL_CYCLES = 40_000,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned RST_BIT    = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 4'd2,
    parameter logic [ADDR_W-1:0] GAIN0_ADDR = 4'd0,
    parameter logic [ADDR_W-1:0] GAIN1_ADDR = 4'd1,
    parameter logic [DATA_W-1:0] CTRL_VAL   = 8'hA9,
    parameter logic [DATA_W-1:0] GAIN0_VAL  = 8'h3C,
    parameter logic [DATA_W-1:0] GAIN1_VAL  = 8'h81
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              vblank,
    input  logic              wr_ack,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done,
    output logic [3:0]        step
);
    localparam int unsigned SETTLE_CYC = ms_to_cycles(CLK_HZ, 1);
    localparam int unsigned GAP_CYC    = ms_to_cycles(CLK_HZ, 2);
    localparam int unsigned MAX_CYC    = max_u(max_u(SETTLE_CYC, GAP_CYC), CAL_CYCLES);
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    seq_step_e        state;
    logic             tclr;
    logic [CNT_W-1:0] tcnt;

    afe_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tclr),
        .cnt (tcnt)
    );

    afe_seq_fsm #(
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC),
        .GAP_CYC    (GAP_CYC),
        .CAL_CYC    (CAL_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .vblank   (vblank),
        .wr_ack   (wr_ack),
        .cnt      (tcnt),
        .state    (state),
        .clr      (tclr)
    );

    afe_seq_wrmux #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .RST_BIT    (RST_BIT),
        .CTRL_ADDR  (CTRL_ADDR),
        .GAIN0_ADDR (GAIN0_ADDR),
        .GAIN1_ADDR (GAIN1_ADDR),
        .CTRL_VAL   (CTRL_VAL),
        .GAIN0_VAL  (GAIN0_VAL),
        .GAIN1_VAL  (GAIN1_VAL)
    ) u_wrmux (
        .state   (state),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    assign done = (state == ST_READY);
    assign step = state;

    assert_settle_len_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SETTLE && state == ST_CTRL_HOLD)
            |-> ($past(tcnt) >= CNT_W'(SETTLE_CYC - 1)));

    assert_gap_len_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_HOLD_GAP && state == ST_CTRL_RUN)
            |-> ($past(tcnt) >= CNT_W'(GAP_CYC - 1)));

    assert_cal_len_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_CALIB && state == ST_GAIN0)
            |-> ($past(tcnt) >= CNT_W'(CAL_CYCLES - 1)));

    assert_hold_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack && pwr_good)
            |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!wr_req && !done && step == 4'd0));
endmodule

// File: tb/afe_bringup_seq_test.sv
`timescale 1ns/1ps
module afe_bringup_seq_test;
    localparam int unsigned CLK_HZ  = 12345;
    localparam int unsigned CAL     = 150;
    localparam int unsigned RST_BIT = 3;
    localparam logic [7:0] CTRL_VAL  = 8'hA9;
    localparam logic [7:0] GAIN0_VAL = 8'h3C;
    localparam logic [7:0] GAIN1_VAL = 8'h81;

    function automatic int ceil_div(int a, int b);
        return (a + b - 1) / b;
    endfunction

    localparam int T1 = (CLK_HZ + 999) / 1000;
    localparam int T2 = (2 * CLK_HZ + 999) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0;
    logic vblank = 1'b0;
    logic wr_ack = 1'b0;
    logic wr_req;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic done;
    logic [3:0] step;

    always #5 clk = ~clk;

    afe_bringup_seq #(
        .CLK_HZ(CLK_HZ), .CAL_CYCLES(CAL), .ADDR_W(4), .DATA_W(8), .RST_BIT(RST_BIT),
        .CTRL_ADDR(4'd2), .GAIN0_ADDR(4'd0), .GAIN1_ADDR(4'd1),
        .CTRL_VAL(CTRL_VAL), .GAIN0_VAL(GAIN0_VAL), .GAIN1_VAL(GAIN1_VAL)
    ) uut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .vblank(vblank), .wr_ack(wr_ack),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .step(step)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int nlog = 0;
    int l_addr[8], l_data[8], l_req[8], l_ack[8], l_vb[8];
    int done_cyc = -1;
    int pwr_cyc = 0;
    int vb_mode = 0;
    int ack_cd = 0;
    logic req_q = 1'b0;
    logic done_q = 1'b0;
    logic [3:0] addr_q = '0;
    logic [7:0] data_q = '0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int ctrl_data(bit rst_level);
        int v;
        v = int'(CTRL_VAL) & ~(1 << RST_BIT);
        if (rst_level) v = v | (1 << RST_BIT);
        return v;
    endfunction

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (wr_req && (!req_q || wr_ack)) begin
            if (nlog < 8) begin
                l_addr[nlog] = int'(wr_addr);
                l_data[nlog] = int'(wr_data);
                l_req[nlog]  = cyc;
                l_vb[nlog]   = int'(vblank);
                l_ack[nlog]  = -1;
            end
            nlog++;
        end else if (wr_req && req_q) begin
            // R8: pending write must not change before acknowledge
            if (wr_addr != addr_q || wr_data != data_q)
                chk(1'b0, "R8", int'(wr_data), int'(data_q));
        end
        if (done && !done_q) done_cyc = cyc;
        if (wr_ack) begin
            wr_ack = 1'b0;
        end else if (wr_req && pwr_good) begin
            if (ack_cd == 0) begin
                wr_ack = 1'b1;
                if (nlog > 0 && nlog <= 8) l_ack[nlog-1] = cyc;
                ack_cd = int'($urandom % 4);
            end else begin
                ack_cd--;
            end
        end
        case (vb_mode)
            1: if ($urandom % 12 == 0) vblank = ~vblank;
            2: vblank = (nlog >= 1 && l_ack[0] >= 0) ? (cyc < l_ack[0] + T2 + 30) : 1'b1;
            default: vblank = 1'b0;
        endcase
        req_q  = wr_req;
        addr_q = wr_addr;
        data_q = wr_data;
        done_q = done;
    endtask

    task automatic run(int mode, int drop_at);
        vb_mode  = mode;
        nlog     = 0;
        done_cyc = -1;
        for (int k = 0; k < 8; k++) l_ack[k] = -1;
        pwr_good = 1'b1;
        pwr_cyc  = cyc;
        for (int i = 0; i < 1500; i++) begin
            tick();
            if (cyc == pwr_cyc + 1) chk(step == 4'd1, "R12 settle code", int'(step), 1);
            if (nlog >= 1 && l_ack[0] >= 0 && cyc == l_ack[0] + 1)
                chk(step == 4'd3, "R12 gap code", int'(step), 3);
            if (nlog >= 2 && l_ack[1] >= 0 && cyc == l_ack[1] + 1)
                chk(step == 4'd5, "R12 calibration code", int'(step), 5);
            if (drop_at >= 0 && cyc - pwr_cyc == drop_at) begin
                pwr_good = 1'b0;
                wr_ack   = 1'b0;
                tick();
                chk(step == 4'd0, "R11 step after drop", int'(step), 0);
                chk(!wr_req && !done, "R11 outputs after drop", int'({wr_req, done}), 0);
                for (int j = 0; j < 6; j++) tick();
                chk(step == 4'd0 && nlog <= 4, "R11 stays idle", int'(step), 0);
                return;
            end
            if (done_cyc >= 0) break;
        end
        chk(done_cyc >= 0, "R10 done reached", done_cyc, 1);
        if (done_cyc < 0) return;
        chk(nlog == 4, "R9 write count", nlog, 4);
        chk(l_addr[0] == 2 && l_addr[1] == 2, "R9 control address order", l_addr[1], 2);
        chk(l_addr[2] == 0, "R9 third address", l_addr[2], 0);
        chk(l_addr[3] == 1, "R9 fourth address", l_addr[3], 1);
        chk(l_data[0] == ctrl_data(1'b0), "R3 reset-low data", l_data[0], ctrl_data(1'b0));
        chk(l_data[1] == ctrl_data(1'b1), "R5 release data", l_data[1], ctrl_data(1'b1));
        chk((l_data[0] ^ l_data[1]) == (1 << RST_BIT), "R5 only reset bit differs",
            l_data[0] ^ l_data[1], 1 << RST_BIT);
        chk(l_data[2] == int'(GAIN0_VAL) && l_data[3] == int'(GAIN1_VAL), "R9 gain data",
            l_data[2], int'(GAIN0_VAL));
        chk(l_req[0] - pwr_cyc == T1 + 1, "R2 settle length", l_req[0] - pwr_cyc, T1 + 1);
        chk(l_req[1] - l_ack[0] >= T2 + 1, "R4 gap minimum", l_req[1] - l_ack[0], T2 + 1);
        if (mode == 0)
            chk(l_req[1] - l_ack[0] == T2 + 1, "R4 gap exact", l_req[1] - l_ack[0], T2 + 1);
        if (mode == 2)
            chk(l_req[1] - l_ack[0] == T2 + 31, "R7 blank hold-off", l_req[1] - l_ack[0], T2 + 31);
        chk(l_vb[1] == 0, "R7 blank low before release", l_vb[1], 0);
        chk(l_req[2] - l_ack[1] == CAL + 1, "R6 calibration length", l_req[2] - l_ack[1], CAL + 1);
        chk(l_req[3] == l_ack[2] + 1, "R8 advance after ack", l_req[3], l_ack[2] + 1);
        chk(done_cyc == l_ack[3] + 1, "R10 done timing", done_cyc, l_ack[3] + 1);
        for (int j = 0; j < 20; j++) tick();
        chk(done && step == 4'd8, "R10 done sticky / R12 ready code", int'(step), 8);
        chk(!wr_req && nlog == 4, "R9 no extra writes", nlog, 4);
        pwr_good = 1'b0;
        tick();
        chk(step == 4'd0 && !done, "R11 drop after done", int'(step), 0);
        for (int j = 0; j < 3; j++) tick();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 3; i++) tick();
        chk(step == 4'd0 && !wr_req && !done, "R1 during reset", int'(step), 0);
        rst = 1'b0;
        tick();
        chk(step == 4'd0 && !wr_req && !done, "R1 after reset", int'(step), 0);
        vb_mode = 1;
        for (int i = 0; i < 10; i++) tick();
        chk(step == 4'd0 && !wr_req, "R11 idle without supply", int'(step), 0);
        run(0, -1);
        run(2, -1);
        for (int r = 0; r < 5; r++) run(1, -1);
        for (int r = 0; r < 4; r++) run(1, 3 + int'($urandom % 220));
        run(0, -1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule